// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block sits beside an integer ALU and turns each completed operation into a set of condition flags. It takes the operation class, the operand size, both operands, the raw result and the ALU's carry-out. When the valid strobe is high, it evaluates carry, even parity, nibble carry, zero, sign and signed overflow at the selected size. It writes them into a flags register according to the operation class. Additions and subtractions update all six arithmetic flags. Logic operations update some and force or keep others. Transfer and control operations leave everything as it was.

Three control flags share the register: trap, interrupt enable and string direction. Downstream logic reads the direction flag to step string indices downward (1) or upward (0), and the interrupt-enable flag to gate the maskable interrupt request. None of the three is ever touched by an operation. They change only through a separate load port, which may be used in the same cycle as an operation.

Top module: `status_flags`

## Requirements
- R1: While `rst_n` is low, and after its release until the first write, all nine bits of `flags_q` are 0.
- R2: For add (`op_kind`=0) and subtract (`op_kind`=1), the carry flag (`flags_q[0]`) takes `alu_cout`, which the ALU drives as the carry out of the top bit for an add and as the borrow into it for a subtract.
- R3: For add, subtract and logic, the parity flag (`flags_q[1]`) is 1 when bits 7:0 of the result hold an even number of ones (zero ones counts as even), whatever the size.
- R4: For add and subtract, the nibble-carry flag (`flags_q[2]`) is `opnd_a[4]^opnd_b[4]^alu_res[4]`, the carry or borrow between bits 3 and 4.
- R5: For add, subtract and logic, the zero flag (`flags_q[3]`) is 1 exactly when the result bits below the size width are all 0; result bits above the width are ignored. The `op_size` values 0, 1, 2 and 3 select widths of 8, 16, 32 and 64 bits.
- R6: For add, subtract and logic, the sign flag (`flags_q[4]`) equals the result bit at index width-1.
- R7: For add, the overflow flag (`flags_q[5]`) is 1 when both operand sign bits are equal and the result sign differs from them.
- R8: For subtract, the overflow flag is 1 when the operand sign bits differ and the result sign differs from that of `opnd_a`.
- R9: A logic operation (`op_kind`=2) clears the carry and overflow flags and leaves the nibble-carry flag unchanged.
- R10: A transfer/control operation (`op_kind`=3), or a cycle with `op_valid` low, leaves `flags_q[5:0]` unchanged.
- R11: The control flags `flags_q[6]` (trap), `flags_q[7]` (interrupt enable) and `flags_q[8]` (direction) load `ctl_in[2:0]` one cycle after `ctl_load` is high, and hold whenever it is low, whatever the operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation completes this cycle |
| op_kind | input | 2 | 0 add, 1 subtract, 2 logic, 3 transfer/control |
| op_size | input | 2 | 0:8, 1:16, 2:32, 3:64 bits |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| alu_res | input | DATA_W | Raw ALU result |
| alu_cout | input | 1 | Carry out (add) or borrow (subtract) at the size |
| ctl_load | input | 1 | Write the control flags |
| ctl_in | input | 3 | {direction, interrupt enable, trap} |
| flags_q | output | 9 | {dir, ie, trap, overflow, sign, zero, nibble carry, parity, carry} |

## Verification
The bench builds the block with the default `DATA_W` of 64, so all four size codes are reachable, including the 64-bit sign and overflow positions. Some vectors put stray ones in the result above the selected width. This shows that zero, sign and parity look only at the bits in range. A 16-bit subtract has an odd count of ones across its width but an even count in its low byte, which separates byte parity from full-width parity. Logic operations follow adds whose nibble carry is 1 and 0, so the held value is seen in both states.

// File: rtl/status_flags.sv
module status_flags #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_cout,
  input  logic              ctl_load,
  input  logic [2:0]        ctl_in,
  output logic [8:0]        flags_q
);
  localparam int IW = $clog2(DATA_W);
  localparam logic [1:0] K_ADD = 2'd0, K_SUB = 2'd1, K_LOG = 2'd2;

  int unsigned      width;
  logic [IW-1:0]    top;
  logic [DATA_W-1:0] in_range;
  logic             sa, sb, sr, par, zer, nib, ovf;

  always_comb begin
    width = ((32'd8 << op_size) > DATA_W) ? DATA_W : (32'd8 << op_size);
    top   = IW'(width - 1);
    for (int i = 0; i < DATA_W; i++) in_range[i] = (i < width);
  end

  assign sa  = opnd_a[top];
  assign sb  = opnd_b[top];
  assign sr  = alu_res[top];
  assign par = ~^alu_res[7:0];
  assign zer = ((alu_res & in_range) == '0);
  assign nib = opnd_a[4] ^ opnd_b[4] ^ alu_res[4];
  assign ovf = (op_kind == K_ADD) ? ((sa == sb) && (sr != sa))
                                  : ((sa != sb) && (sr != sa));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      if (op_valid) begin
        case (op_kind)
          K_ADD, K_SUB: flags_q[5:0] <= {ovf, sr, zer, nib, par, alu_cout};
          K_LOG:        flags_q[5:0] <= {1'b0, sr, zer, flags_q[2], par, 1'b0};
          default:      flags_q[5:0] <= flags_q[5:0];
        endcase
      end
      if (ctl_load) flags_q[8:6] <= ctl_in;
    end
  end
endmodule

module status_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_kind,
  input logic       ctl_load,
  input logic [2:0] ctl_in,
  input logic [8:0] flags_q
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags_q[5:0])); // R10
  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd3) |=> $stable(flags_q[5:0])); // R10
  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'd2) |=> (!flags_q[0] && !flags_q[5] && $stable(flags_q[2]))); // R9
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_load |=> (flags_q[8:6] == $past(ctl_in))); // R11
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_load |=> $stable(flags_q[8:6])); // R11
  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind != 2'd3) |=> !(flags_q[3] && flags_q[4])); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (flags_q == 9'd0)); // R1
endmodule

bind status_flags status_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .ctl_load(ctl_load), .ctl_in(ctl_in), .flags_q(flags_q)
);

// File: tb/test_status_flags.sv
module test_status_flags;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        op_valid = 0;
  logic [1:0]  op_kind = 0;
  logic [1:0]  op_size = 0;
  logic [63:0] opnd_a = 0, opnd_b = 0, alu_res = 0;
  logic        alu_cout = 0;
  logic        ctl_load = 0;
  logic [2:0]  ctl_in = 0;
  logic [8:0]  flags_q;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  status_flags i_status_flags (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_size(op_size), .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_res(alu_res),
    .alu_cout(alu_cout), .ctl_load(ctl_load), .ctl_in(ctl_in), .flags_q(flags_q)
  );

  // {kind, size, a, b, res, cout, expected {of,sf,zf,af,pf,cf}}
  localparam int NV = 11;
  localparam logic [202:0] VEC [NV] = '{
    {2'd0, 2'd0, 64'h0F, 64'h01, 64'h10, 1'b0, 6'b000100},                 // R4 nibble carry, R3 odd
    {2'd0, 2'd0, 64'h7F, 64'h01, 64'h80, 1'b0, 6'b110100},                 // R7 R6
    {2'd0, 2'd0, 64'hFF, 64'h01, 64'h100, 1'b1, 6'b001111},                // R2 R5
    {2'd1, 2'd1, 64'h8000, 64'h0001, 64'h7FFF, 1'b0, 6'b100110},           // R8 R3 byte parity
    {2'd1, 2'd2, 64'h0, 64'h1, 64'hFFFF_FFFF, 1'b1, 6'b010111},            // R2 borrow
    {2'd2, 2'd3, 64'h5, 64'h3, 64'h8000_0000_0000_0003, 1'b1, 6'b010110},  // R9 af held 1
    {2'd3, 2'd0, 64'h0, 64'h0, 64'h0, 1'b1, 6'b010110},                    // R10
    {2'd0, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000, 1'b0, 6'b110110}, // R7 64
    {2'd2, 2'd1, 64'h1, 64'h2, 64'hABCD_0000, 1'b1, 6'b001110},            // R9 R5
    {2'd0, 2'd2, 64'h1_0000_0000, 64'h0, 64'hFFFF_FFFF_0000_0000, 1'b0, 6'b001010}, // R5 masked
    {2'd2, 2'd0, 64'h0, 64'h0, 64'h0100, 1'b1, 6'b001010}                  // R9 af held 0
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] ctl;
    @(negedge clk);
    check("R1 in reset", flags_q, 9'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", flags_q, 9'd0);

    ctl = 3'b000;
    for (int i = 0; i < NV; i++) begin
      {op_kind, op_size, opnd_a, opnd_b, alu_res, alu_cout} = VEC[i][202:6];
      op_valid = 1;
      @(negedge clk);
      op_valid = 0;
      check($sformatf("R2-group vector %0d", i), flags_q, {ctl, VEC[i][5:0]});
    end

    // R10: idle cycle with arithmetic-looking inputs
    op_kind = 2'd0; op_size = 2'd0; opnd_a = 64'h7F; opnd_b = 64'h1; alu_res = 64'h80; alu_cout = 1;
    op_valid = 0;
    @(negedge clk);
    check("R10 idle hold", flags_q, {3'b000, 6'b001010});

    // R11: load control flags alongside an add
    ctl_load = 1; ctl_in = 3'b101; op_valid = 1;
    @(negedge clk);
    ctl_load = 0; op_valid = 0;
    check("R11 load with op", flags_q, {3'b101, 6'b110101});

    // R11: control flags hold while operations continue
    ctl_in = 3'b010; op_valid = 1; op_kind = 2'd2; alu_res = 64'h0;
    @(negedge clk);
    op_valid = 0;
    check("R11 hold R9", flags_q, {3'b101, 6'b001110});

    ctl_load = 1; ctl_in = 3'b010;
    @(negedge clk);
    ctl_load = 0;
    check("R11 reload", flags_q, {3'b010, 6'b001110});

    // R1: reset mid-run
    rst_n = 0;
    @(negedge clk);
    check("R1 mid-run reset", flags_q, 9'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 stays clear", flags_q, 9'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule